// File: doc/BRIEF.md
# Stop-Mode Power Controller

This block decides when a small microcontroller's core may run. Software enters a low-power stop state by writing to a power-control register. That register is guarded: a write to it counts only if the write just before it on the same port put an unlock key into a separate command register. When the stop state is entered, the controller switches off the enables for the CPU clock, the internal system clock, the peripheral clock and the oscillator. It also raises a retention request, so that register and RAM contents are kept. While the core is not running, the external bus interface is parked in a fixed state.

A wake event ends the stop state. With a crystal oscillator attached, the controller first waits a stabilization interval whose length is set by a field of the power register, and only then turns the clocks back on. With a direct external clock it turns the clocks on at once. An asynchronous reset returns the block to the running state from any state.

The oscillator, the memories and the clock-output divider are outside this block. It sees them only through enable and status signals.

Top module: `pwr_stop_ctrl`

## Requirements
- R1: While `pwr_state` is STOP (encoding: RUN=0, STOP=1, STABILIZE=2), `cpu_clk_en`, `sys_clk_en`, `periph_clk_en` and `osc_en` are all 0 and `stop_active` is 1.
- R2: The only way into STOP is a write with `wr_sel`=1 (power register) and `wr_data[0]`=1, where the write immediately before it on the port had `wr_sel`=0 (command register) and data equal to the key `KEY` (default 8'hA5). The clock enables drop in the cycle after the clock edge that captures the power write.
- R3: When `ext_clk_sel`=1 and `wake_irq` is sampled high in STOP, the state is RUN in the very next cycle, with all clock enables at 1.
- R4: When `ext_clk_sel`=0 and `wake_irq` is sampled high in STOP, the block spends exactly 2^(STAB_BASE+s) cycles in STABILIZE and then returns to RUN. Here s is `wr_data[3:1]` of the last accepted power write. In STABILIZE, `osc_en` is 1 and the other clock enables are 0.
- R5: `retain` is 1 whenever the state is not RUN, and 0 in RUN.
- R6: `pad_ad_oe` is forced to 0 (bus high-impedance) whenever the state is not RUN. In RUN it follows `core_ad_oe`.
- R7: `pad_hldak` is forced to 0 whenever the state is not RUN. In RUN it follows `core_hldak`.
- R8: While not in RUN, `pad_ahi` and `pad_ctl` hold the values that the core drove in the last RUN cycle. In RUN they follow the core.
- R9: An accepted stop write made while `clkout_en`=1 is refused: the state stays RUN and `clkout_err` is set.
- R10: A power write that does not directly follow a key write (no key, wrong data, or another write in between) is ignored and sets `prot_err`. Every accepted power write clears `prot_err`, and clears `clkout_err` unless that write itself sets it.
- R11: `wake_irq` has no effect in RUN, and a pulse of it during STABILIZE does not change the length of the wait.
- R12: Asserting `rst_n` low sets RUN at once from any state, including STABILIZE. All clock enables go to 1, `retain` goes to 0, and both error flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (oscillator domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe from the CPU |
| wr_sel | input | 1 | 0 = command (key) register, 1 = power register |
| wr_data | input | DATA_W | Write data; bit 0 is the stop request, bits 3:1 the stabilization select |
| clkout_en | input | 1 | Clock-output enable status |
| ext_clk_sel | input | 1 | 1 = direct external clock, 0 = crystal oscillator |
| wake_irq | input | 1 | Unmasked interrupt wake request |
| core_ad_do | input | AD_W | Core address/data output value |
| core_ad_oe | input | 1 | Core address/data output enable |
| core_ahi | input | AHI_W | Core upper address lines |
| core_ctl | input | CTL_W | Core byte-enable, read/write and strobe lines |
| core_hldak | input | 1 | Core hold-acknowledge |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | Internal system clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| retain | output | 1 | Register/RAM retention request |
| stop_active | output | 1 | High in STOP |
| pwr_state | output | 2 | Current state (RUN=0, STOP=1, STABILIZE=2) |
| prot_err | output | 1 | Unprotected power write seen |
| clkout_err | output | 1 | Stop refused because the clock output was enabled |
| pad_ad_do | output | AD_W | Address/data value toward the pads |
| pad_ad_oe | output | 1 | Address/data pad output enable |
| pad_ahi | output | AHI_W | Upper address lines toward the pads |
| pad_ctl | output | CTL_W | Control lines toward the pads |
| pad_hldak | output | 1 | Hold-acknowledge toward the pads |

## Verification
The bound checker tests on every cycle the properties that relate a state to the outputs in that cycle or the next one. These are: the clock enables are off in STOP, retention is on and the pads are parked while the core is halted, the parked control lines stay steady, and a wake in external-clock mode restores the clocks on the next cycle. It also checks that the clock enables can only fall right after a power write, and that a stop request made while the clock output is enabled leaves the clocks running. Some behaviours depend on history that a single clocked property cannot capture. These are the exact stabilization length for each select value, the key-then-write protection with its error flags, the indifference to a wake pulse in the middle of the wait, and a reset that cuts the wait short. Only the bench's directed and random scenarios, compared against its own model, can show them.

// File: rtl/pwr_stop_pkg.sv
package pwr_stop_pkg;

   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_STOP = 2'd1,
      PS_STAB = 2'd2
   } pwr_state_e;

   localparam logic SEL_CMD = 1'b0;
   localparam logic SEL_PWR = 1'b1;

endpackage

// File: rtl/pwr_unlock_gate.sv
module pwr_unlock_gate #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEL_W  = 3,
   parameter logic [DATA_W-1:0] KEY = 'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clkout_en,
   output logic              stop_req,
   output logic [SEL_W-1:0]  stab_sel,
   output logic              prot_err,
   output logic              clkout_err
);
   import pwr_stop_pkg::*;

   logic armed_q;
   logic pwr_wr;
   logic accept;
   logic reject;
   logic want_stop;

   assign pwr_wr    = wr_en && (wr_sel == SEL_PWR);
   assign accept    = pwr_wr && armed_q;
   assign reject    = pwr_wr && !armed_q;
   assign want_stop = wr_data[0];
   assign stop_req  = accept && want_stop && !clkout_en;

   // the key arms exactly one following write, whatever it is
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (wr_en) begin
         armed_q <= (wr_sel == SEL_CMD) && (wr_data == KEY);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stab_sel   <= '1;
         prot_err   <= 1'b0;
         clkout_err <= 1'b0;
      end else if (accept) begin
         stab_sel   <= wr_data[SEL_W:1];
         prot_err   <= 1'b0;
         clkout_err <= want_stop && clkout_en;
      end else if (reject) begin
         prot_err   <= 1'b1;
      end
   end

endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
   parameter int unsigned STAB_BASE = 13,
   parameter int unsigned SEL_W     = 3,
   localparam int unsigned CNT_W    = STAB_BASE + (1 << SEL_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] sel,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   // interval length is 2^(STAB_BASE+sel); count runs from length-1 to 0
   assign load_val = (CNT_W'(1) << (CNT_W'(STAB_BASE) + CNT_W'(sel))) - CNT_W'(1);
   assign done     = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (!done) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/pwr_bus_park.sv
module pwr_bus_park #(
   parameter int unsigned AD_W      = 16,
   parameter int unsigned AHI_W     = 8,
   parameter int unsigned CTL_W     = 6,
   parameter bit          HOLD_LAST = 1'b1,
   parameter logic [CTL_W-1:0] CTL_IDLE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             park,
   input  logic [AD_W-1:0]  core_ad_do,
   input  logic             core_ad_oe,
   input  logic [AHI_W-1:0] core_ahi,
   input  logic [CTL_W-1:0] core_ctl,
   input  logic             core_hldak,
   output logic [AD_W-1:0]  pad_ad_do,
   output logic             pad_ad_oe,
   output logic [AHI_W-1:0] pad_ahi,
   output logic [CTL_W-1:0] pad_ctl,
   output logic             pad_hldak
);
   assign pad_ad_do = core_ad_do;
   assign pad_ad_oe = core_ad_oe && !park;
   assign pad_hldak = core_hldak && !park;

   generate
      if (HOLD_LAST) begin : g_hold
         logic [AHI_W-1:0] ahi_q;
         logic [CTL_W-1:0] ctl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ahi_q <= '0;
               ctl_q <= CTL_IDLE;
            end else if (!park) begin
               ahi_q <= core_ahi;
               ctl_q <= core_ctl;
            end
         end

         assign pad_ahi = park ? ahi_q : core_ahi;
         assign pad_ctl = park ? ctl_q : core_ctl;
      end else begin : g_idle
         assign pad_ahi = park ? '0 : core_ahi;
         assign pad_ctl = park ? CTL_IDLE : core_ctl;
      end
   endgenerate

endmodule

// File: rtl/pwr_stop_ctrl.sv
module pwr_stop_ctrl #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned STAB_BASE = 13,
   parameter int unsigned AD_W      = 16,
   parameter int unsigned AHI_W     = 8,
   parameter int unsigned CTL_W     = 6,
   parameter bit          HOLD_LAST = 1'b1,
   parameter logic [DATA_W-1:0] KEY = 'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clkout_en,
   input  logic              ext_clk_sel,
   input  logic              wake_irq,
   input  logic [AD_W-1:0]   core_ad_do,
   input  logic              core_ad_oe,
   input  logic [AHI_W-1:0]  core_ahi,
   input  logic [CTL_W-1:0]  core_ctl,
   input  logic              core_hldak,
   output logic              cpu_clk_en,
   output logic              sys_clk_en,
   output logic              periph_clk_en,
   output logic              osc_en,
   output logic              retain,
   output logic              stop_active,
   output logic [1:0]        pwr_state,
   output logic              prot_err,
   output logic              clkout_err,
   output logic [AD_W-1:0]   pad_ad_do,
   output logic              pad_ad_oe,
   output logic [AHI_W-1:0]  pad_ahi,
   output logic [CTL_W-1:0]  pad_ctl,
   output logic              pad_hldak
);
   import pwr_stop_pkg::*;

   generate
      if (DATA_W < SEL_W + 1) begin : g_chk_data_w
         $error("pwr_stop_ctrl: DATA_W too narrow for stop bit plus select field");
      end
      if (STAB_BASE < 1) begin : g_chk_base
         $error("pwr_stop_ctrl: STAB_BASE must be at least 1");
      end
      if (SEL_W < 1 || SEL_W > 4) begin : g_chk_sel_w
         $error("pwr_stop_ctrl: SEL_W must be 1..4");
      end
   endgenerate

   pwr_state_e       state_q;
   logic             run;
   logic             wr_en_run;
   logic             stop_req;
   logic [SEL_W-1:0] stab_sel;
   logic             stab_load;
   logic             stab_done;

   assign run       = (state_q == PS_RUN);
   assign wr_en_run = wr_en && run;
   assign stab_load = (state_q == PS_STOP) && wake_irq && !ext_clk_sel;

   pwr_unlock_gate #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .KEY    (KEY)
   ) u_unlock (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en_run),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .clkout_en  (clkout_en),
      .stop_req   (stop_req),
      .stab_sel   (stab_sel),
      .prot_err   (prot_err),
      .clkout_err (clkout_err)
   );

   pwr_stab_timer #(
      .STAB_BASE (STAB_BASE),
      .SEL_W     (SEL_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (stab_load),
      .sel   (stab_sel),
      .done  (stab_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_RUN;
      end else begin
         unique case (state_q)
            PS_RUN:  if (stop_req)  state_q <= PS_STOP;
            PS_STOP: if (wake_irq)  state_q <= ext_clk_sel ? PS_RUN : PS_STAB;
            PS_STAB: if (stab_done) state_q <= PS_RUN;
            default:                state_q <= PS_RUN;
         endcase
      end
   end

   assign cpu_clk_en    = run;
   assign sys_clk_en    = run;
   assign periph_clk_en = run;
   assign osc_en        = (state_q != PS_STOP);
   assign retain        = !run;
   assign stop_active   = (state_q == PS_STOP);
   assign pwr_state     = state_q;

   pwr_bus_park #(
      .AD_W      (AD_W),
      .AHI_W     (AHI_W),
      .CTL_W     (CTL_W),
      .HOLD_LAST (HOLD_LAST)
   ) u_park (
      .clk        (clk),
      .rst_n      (rst_n),
      .park       (!run),
      .core_ad_do (core_ad_do),
      .core_ad_oe (core_ad_oe),
      .core_ahi   (core_ahi),
      .core_ctl   (core_ctl),
      .core_hldak (core_hldak),
      .pad_ad_do  (pad_ad_do),
      .pad_ad_oe  (pad_ad_oe),
      .pad_ahi    (pad_ahi),
      .pad_ctl    (pad_ctl),
      .pad_hldak  (pad_hldak)
   );

endmodule

// File: rtl/pwr_stop_ctrl_chk.sv
module pwr_stop_ctrl_chk #(
   parameter int unsigned AHI_W = 8,
   parameter int unsigned CTL_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_sel,
   input logic             wr_bit0,
   input logic             clkout_en,
   input logic             ext_clk_sel,
   input logic             wake_irq,
   input logic             cpu_clk_en,
   input logic             sys_clk_en,
   input logic             periph_clk_en,
   input logic             osc_en,
   input logic             retain,
   input logic             stop_active,
   input logic             pad_ad_oe,
   input logic             pad_hldak,
   input logic [AHI_W-1:0] pad_ahi,
   input logic [CTL_W-1:0] pad_ctl
);

   p_clocks_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_active |-> (!cpu_clk_en && !sys_clk_en && !periph_clk_en && !osc_en));

   p_entry_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_clk_en) |-> $past(wr_en && wr_sel && wr_bit0 && !clkout_en));

   p_ext_wake_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_active && wake_irq && ext_clk_sel) |=> cpu_clk_en);

   p_osc_wake_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_active && wake_irq && !ext_clk_sel) |=> (!cpu_clk_en && osc_en && !stop_active));

   p_retain_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_clk_en |-> retain);

   p_ad_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_clk_en |-> !pad_ad_oe);

   p_hldak_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_clk_en |-> !pad_hldak);

   p_ctl_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_clk_en && $past(!cpu_clk_en)) |-> ($stable(pad_ahi) && $stable(pad_ctl)));

   p_clkout_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && wr_en && wr_sel && wr_bit0 && clkout_en) |=> cpu_clk_en);

   p_wake_in_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && wake_irq && !(wr_en && wr_sel && wr_bit0)) |=> cpu_clk_en);

endmodule

bind pwr_stop_ctrl pwr_stop_ctrl_chk #(
   .AHI_W (AHI_W),
   .CTL_W (CTL_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_sel        (wr_sel),
   .wr_bit0       (wr_data[0]),
   .clkout_en     (clkout_en),
   .ext_clk_sel   (ext_clk_sel),
   .wake_irq      (wake_irq),
   .cpu_clk_en    (cpu_clk_en),
   .sys_clk_en    (sys_clk_en),
   .periph_clk_en (periph_clk_en),
   .osc_en        (osc_en),
   .retain        (retain),
   .stop_active   (stop_active),
   .pad_ad_oe     (pad_ad_oe),
   .pad_hldak     (pad_hldak),
   .pad_ahi       (pad_ahi),
   .pad_ctl       (pad_ctl)
);

// File: tb/pwr_stop_ctrl_bench.sv
module pwr_stop_ctrl_bench;
   localparam int unsigned DW = 8, ADW = 16, AHW = 8, CW = 6, SW = 3, BASE = 3;
   localparam logic [7:0] KEY = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_sel = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic clkout_en = 1'b0, ext_clk_sel = 1'b0, wake_irq = 1'b0;
   logic [ADW-1:0] core_ad_do = '0;
   logic core_ad_oe = 1'b0, core_hldak = 1'b0;
   logic [AHW-1:0] core_ahi = '0;
   logic [CW-1:0] core_ctl = '0;
   logic cpu_clk_en, sys_clk_en, periph_clk_en, osc_en, retain, stop_active;
   logic [1:0] pwr_state;
   logic prot_err, clkout_err;
   logic [ADW-1:0] pad_ad_do;
   logic pad_ad_oe, pad_hldak;
   logic [AHW-1:0] pad_ahi;
   logic [CW-1:0] pad_ctl;

   always #4 clk = ~clk;

   pwr_stop_ctrl #(.STAB_BASE(BASE)) u_pwr_stop_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .clkout_en(clkout_en), .ext_clk_sel(ext_clk_sel), .wake_irq(wake_irq),
      .core_ad_do(core_ad_do), .core_ad_oe(core_ad_oe), .core_ahi(core_ahi),
      .core_ctl(core_ctl), .core_hldak(core_hldak),
      .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .periph_clk_en(periph_clk_en),
      .osc_en(osc_en), .retain(retain), .stop_active(stop_active), .pwr_state(pwr_state),
      .prot_err(prot_err), .clkout_err(clkout_err), .pad_ad_do(pad_ad_do),
      .pad_ad_oe(pad_ad_oe), .pad_ahi(pad_ahi), .pad_ctl(pad_ctl), .pad_hldak(pad_hldak));

   int checks = 0, fails = 0;
   bit done = 1'b0;
   bit m_armed = 1'b0, m_perr = 1'b0, m_cerr = 1'b0;
   logic [AHW-1:0] snap_ahi;
   logic [CW-1:0] snap_ctl;

   function automatic int stab_len(logic [2:0] s);
      return 1 << (BASE + s);
   endfunction

   task automatic eq(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive_core_random();
      core_ad_do = 16'($urandom);
      core_ad_oe = 1'b1;
      core_hldak = 1'b1;
      core_ahi   = 8'($urandom);
      core_ctl   = 6'($urandom);
   endtask

   task automatic wr(bit sel, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (sel == 1'b0) m_armed = (d == KEY);
      else begin
         if (m_armed) begin
            m_perr = 1'b0;
            m_cerr = d[0] & clkout_en;
         end else m_perr = 1'b1;
         m_armed = 1'b0;
      end
   endtask

   task automatic check_run(string req);
      eq({req, " state"}, 32'(pwr_state), 32'd0);
      eq({req, " clocks"}, {29'd0, cpu_clk_en, sys_clk_en, periph_clk_en}, 32'd7);
      eq({req, " osc_en"}, 32'(osc_en), 32'd1);
      eq({req, " retain"}, 32'(retain), 32'd0);
   endtask

   task automatic check_flags(string req);
      eq({req, " prot_err"}, 32'(prot_err), 32'(m_perr));
      eq({req, " clkout_err"}, 32'(clkout_err), 32'(m_cerr));
   endtask

   // returns 1 when STOP is expected to be entered
   task automatic try_stop(bit use_key, bit interpose, logic [2:0] s, bit cke, output bit entered);
      clkout_en = cke;
      @(negedge clk);
      drive_core_random();
      snap_ahi = core_ahi;
      snap_ctl = core_ctl;
      if (use_key) wr(1'b0, KEY);
      if (interpose) wr(1'b0, 8'h3C);
      wr(1'b1, {4'h0, s, 1'b1});
      entered = use_key && !interpose && !cke;
      eq("R2 R9 R10 entry decision", 32'(pwr_state), entered ? 32'd1 : 32'd0);
      check_flags("R10 flags");
      if (entered) begin
         eq("R1 clocks off", {28'd0, cpu_clk_en, sys_clk_en, periph_clk_en, osc_en}, 32'd0);
         eq("R1 stop_active", 32'(stop_active), 32'd1);
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            drive_core_random();
            #1;
            eq("R5 retain in stop", 32'(retain), 32'd1);
            eq("R6 ad high-z", 32'(pad_ad_oe), 32'd0);
            eq("R7 hldak low", 32'(pad_hldak), 32'd0);
            eq("R8 ahi held", 32'(pad_ahi), 32'(snap_ahi));
            eq("R8 ctl held", 32'(pad_ctl), 32'(snap_ctl));
         end
      end else begin
         check_run("R9 R10 stayed running");
      end
      clkout_en = 1'b0;
   endtask

   task automatic do_wake(bit ext, logic [2:0] s, bit mid_wake);
      int n;
      ext_clk_sel = ext;
      @(negedge clk); wake_irq = 1'b1;
      @(negedge clk); wake_irq = 1'b0;
      if (ext) begin
         check_run("R3 direct wake");
      end else begin
         n = stab_len(s);
         eq("R4 stabilizing", 32'(pwr_state), 32'd2);
         eq("R4 osc on", 32'(osc_en), 32'd1);
         eq("R4 cpu off", 32'(cpu_clk_en), 32'd0);
         eq("R5 retain in stab", 32'(retain), 32'd1);
         eq("R6 ad high-z in stab", 32'(pad_ad_oe), 32'd0);
         for (int i = 0; i < n - 2; i++) begin
            @(negedge clk);
            wake_irq = mid_wake && (i == 2);
         end
         @(negedge clk);
         wake_irq = 1'b0;
         eq(mid_wake ? "R11 R4 last wait cycle" : "R4 last wait cycle", 32'(pwr_state), 32'd2);
         @(negedge clk);
         check_run("R4 clocks back");
      end
      drive_core_random();
      #1;
      eq("R8 ahi follows core", 32'(pad_ahi), 32'(core_ahi));
      eq("R6 ad oe follows core", 32'(pad_ad_oe), 32'd1);
      eq("R7 hldak follows core", 32'(pad_hldak), 32'd1);
   endtask

   initial begin
      bit ent;
      void'($urandom(32'd20240611));
      #1;
      check_run("R12 reset");
      check_flags("R12 reset flags");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: wake in RUN has no effect
      @(negedge clk); wake_irq = 1'b1;
      @(negedge clk); wake_irq = 1'b0;
      check_run("R11 wake in run");

      // R10: unprotected write
      wr(1'b1, 8'h01);
      check_run("R10 unprotected ignored");
      eq("R10 prot_err set", 32'(prot_err), 32'd1);

      // protected stop, oscillator mode, shortest wait, wake pulse mid-wait
      try_stop(1'b1, 1'b0, 3'd0, 1'b0, ent);
      if (ent) do_wake(1'b0, 3'd0, 1'b1);

      // direct external clock mode
      try_stop(1'b1, 1'b0, 3'd2, 1'b0, ent);
      if (ent) do_wake(1'b1, 3'd2, 1'b0);

      // R9: clock output still enabled
      try_stop(1'b1, 1'b0, 3'd1, 1'b1, ent);
      eq("R9 clkout_err set", 32'(clkout_err), 32'd1);

      // R10: intervening write breaks the unlock
      try_stop(1'b1, 1'b1, 3'd1, 1'b0, ent);

      // longest wait in oscillator mode
      try_stop(1'b1, 1'b0, 3'd7, 1'b0, ent);
      if (ent) do_wake(1'b0, 3'd7, 1'b0);

      // R12: reset during STABILIZE
      try_stop(1'b1, 1'b0, 3'd6, 1'b0, ent);
      ext_clk_sel = 1'b0;
      @(negedge clk); wake_irq = 1'b1;
      @(negedge clk); wake_irq = 1'b0;
      repeat (5) @(negedge clk);
      eq("R12 in stab before reset", 32'(pwr_state), 32'd2);
      rst_n = 1'b0;
      #1;
      m_armed = 1'b0; m_perr = 1'b0; m_cerr = 1'b0;
      check_run("R12 reset in stab");
      check_flags("R12 reset in stab flags");
      @(negedge clk); rst_n = 1'b1;

      // constrained random sessions
      for (int it = 0; it < 24; it++) begin
         bit k, ip, ck, ex, mw;
         logic [2:0] s;
         k  = ($urandom % 4) != 0;
         ip = ($urandom % 5) == 0;
         ck = ($urandom % 5) == 0;
         ex = ($urandom % 2) == 1;
         mw = ($urandom % 3) == 0;
         s  = 3'($urandom % 6);
         try_stop(k, ip, s, ck, ent);
         if (ent) do_wake(ex, s, mw);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule